// File: doc/BRIEF.md
# Raster and vsync interrupt unit

This block counts the scanlines of a 525-line video frame and turns the count into two interrupt sources. One source reports that the count sits in the vertical sync band. The other reports that the count equals a line number that software programs. Two further sources, a sprite event and a serial event, arrive from outside as one-cycle request pulses. All four sources share one status register and one enable register. A single active-high request line goes high whenever an enabled source is pending.

The CPU reaches the unit through a byte-wide register port. Writes take effect on the clock edge, and reads return combinationally for the selected address. Address 0 is the enable register, which keeps the low four bits of a write. Address 1 is the status register. A write to it clears each bit written as 1, and a read shows only the bits that are also enabled. Addresses 2 and 3 hold the 9-bit compare line: address 2 holds the low byte, and bit 0 of address 3 holds the top bit. The line counter advances on a one-cycle line strobe. The vsync and raster status bits are re-evaluated for the new line at each strobe.

Top module: `rstr_irq_unit`

## Requirements
- R1: After reset the line counter is 0. Each cycle with `line_stb` high advances it by one, a strobe at line 524 returns it to 0, and without a strobe it holds.
- R2: On each strobe, status bit 0 (vsync) takes the value 1 if the new line is in 492..495 inclusive, and 0 otherwise.
- R3: On each strobe, status bit 1 (raster) takes the value 1 if the new line equals the compare line, and 0 otherwise. The comparison uses the compare value held before that edge.
- R4: A write to address 2 sets compare bits 7..0 from the write data. A write to address 3 sets compare bit 8 from data bit 0. A read of address 2 returns bits 7..0, and a read of address 3 returns bit 8 in bit 0 with zeros above.
- R5: A write to address 0 stores data bits 3..0 as the enable mask, and the upper data bits are ignored. A read of address 0 returns the mask in bits 3..0 with zeros above.
- R6: A write to address 1 clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R7: A read of address 1 returns status AND enable in bits 3..0 with zeros above. `irq_o` is high exactly when that AND is non-zero.
- R8: A pulse on `ext_set[0]` sets status bit 2 (sprite), and a pulse on `ext_set[1]` sets status bit 3 (serial). In the same cycle, a set or a strobe update takes priority over a clear.
- R9: Reset clears the enable mask, the status bits and the compare line, and holds `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse that advances the line counter |
| ext_set | input | 2 | External request pulses: bit 0 is sprite, bit 1 is serial |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 status, 2 compare low, 3 compare high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request, active high |
| line_o | output | 10 | Current line counter value |

## Verification
The bench builds the unit with its default parameters: a 525-line frame, a sync band of 492 to 495, a 9-bit compare line and two external sources. Because a strobe costs only two bench cycles, the full frame is affordable. This brings the wrap at line 524, both edges of the sync band and a compare line above 255 within reach in one run. A single cycle that combines a strobe, both external pulses and an all-ones clear exercises the set-over-clear priority on all four status bits at once.

// File: rtl/rstr_pkg.sv
package rstr_pkg;

  typedef enum logic [1:0] {
    RS_ENABLE = 2'd0,
    RS_STATUS = 2'd1,
    RS_CMP_LO = 2'd2,
    RS_CMP_HI = 2'd3
  } rstr_reg_e;

  localparam int unsigned SRC_VSYNC  = 0;
  localparam int unsigned SRC_RASTER = 1;
  localparam int unsigned SRC_EXT0   = 2;

  // next scanline number with wrap at the frame end
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned total);
    return (cur == total - 1) ? 0 : cur + 1;
  endfunction

  // inclusive range test
  function automatic logic in_window(int unsigned v, int unsigned lo, int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic lines_match(int unsigned a, int unsigned b);
    return a == b;
  endfunction

endpackage

// File: rtl/rstr_line_ctr.sv
module rstr_line_ctr #(
  parameter int unsigned TOTAL  = 525,
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_nx
);

  always_comb begin
    line_nx = LINE_W'(rstr_pkg::wrap_next(32'(line_q), TOTAL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (line_stb) begin
      line_q <= line_nx;
    end
  end

endmodule

// File: rtl/rstr_status_bits.sv
module rstr_status_bits #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_mask,
  input  logic [NSRC-1:0] upd_mask,
  input  logic [NSRC-1:0] upd_val,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] stat_q
);

  logic [NSRC-1:0] stat_d;

  // per bit priority: set, then strobe update, then clear, then hold
  generate
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
      assign stat_d[b] = set_mask[b] ? 1'b1 :
                         upd_mask[b] ? upd_val[b] :
                         clr_mask[b] ? 1'b0 : stat_q[b];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/rstr_regs.sv
module rstr_regs #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned CMP_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic [NSRC-1:0]  stat_q,
  output logic [NSRC-1:0]  en_q,
  output logic [CMP_W-1:0] cmp_q,
  output logic [NSRC-1:0]  clr_mask,
  output logic [7:0]       rdata
);
  import rstr_pkg::*;

  localparam int unsigned HI_W = CMP_W - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cmp_q <= '0;
    end else if (wr_en) begin
      case (addr)
        RS_ENABLE: en_q <= wdata[NSRC-1:0];
        RS_CMP_LO: cmp_q[7:0] <= wdata;
        RS_CMP_HI: cmp_q[CMP_W-1:8] <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_mask = (wr_en && addr == RS_STATUS) ? wdata[NSRC-1:0] : '0;
  end

  always_comb begin
    case (addr)
      RS_ENABLE: rdata = 8'(en_q);
      RS_STATUS: rdata = 8'(stat_q & en_q);
      RS_CMP_LO: rdata = cmp_q[7:0];
      default:   rdata = 8'(cmp_q[CMP_W-1:8]);
    endcase
  end

endmodule

// File: rtl/rstr_irq_unit.sv
module rstr_irq_unit #(
  parameter int unsigned LINES_PER_FRAME = 525,
  parameter int unsigned SYNC_FIRST      = 492,
  parameter int unsigned SYNC_LAST       = 495,
  parameter int unsigned NUM_EXT         = 2,
  parameter int unsigned CMP_W           = 9,
  parameter int unsigned LINE_W          = $clog2(LINES_PER_FRAME)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_stb,
  input  logic [NUM_EXT-1:0] ext_set,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_o,
  output logic [LINE_W-1:0]  line_o
);
  import rstr_pkg::*;

  localparam int unsigned NSRC = NUM_EXT + 2;

  logic [LINE_W-1:0] line_nx;
  logic [NSRC-1:0]   stat_q;
  logic [NSRC-1:0]   en_q;
  logic [CMP_W-1:0]  cmp_q;
  logic [NSRC-1:0]   clr_mask;
  logic [NSRC-1:0]   set_mask;
  logic [NSRC-1:0]   upd_mask;
  logic [NSRC-1:0]   upd_val;
  logic [NSRC-1:0]   eff_stat;
  logic              vsync_hit;
  logic              raster_hit;

  rstr_line_ctr #(
    .TOTAL (LINES_PER_FRAME),
    .LINE_W(LINE_W)
  ) i_line_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_stb(line_stb),
    .line_q  (line_o),
    .line_nx (line_nx)
  );

  // conditions evaluated for the line the counter moves to
  assign vsync_hit  = in_window(32'(line_nx), SYNC_FIRST, SYNC_LAST);
  assign raster_hit = lines_match(32'(line_nx), 32'(cmp_q));

  always_comb begin
    upd_mask = '0;
    upd_val  = '0;
    if (line_stb) begin
      upd_mask[SRC_VSYNC]  = 1'b1;
      upd_mask[SRC_RASTER] = 1'b1;
    end
    upd_val[SRC_VSYNC]  = vsync_hit;
    upd_val[SRC_RASTER] = raster_hit;
    set_mask = {ext_set, 2'b00};
  end

  rstr_status_bits #(
    .NSRC(NSRC)
  ) i_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_mask(set_mask),
    .upd_mask(upd_mask),
    .upd_val (upd_val),
    .clr_mask(clr_mask),
    .stat_q  (stat_q)
  );

  rstr_regs #(
    .NSRC (NSRC),
    .CMP_W(CMP_W)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .cmp_q   (cmp_q),
    .clr_mask(clr_mask),
    .rdata   (reg_rdata)
  );

  assign eff_stat = stat_q & en_q;
  assign irq_o    = |eff_stat;

endmodule

// File: rtl/rstr_irq_chk.sv
module rstr_irq_chk #(
  parameter int unsigned LINES_PER_FRAME = 525,
  parameter int unsigned SYNC_FIRST      = 492,
  parameter int unsigned SYNC_LAST       = 495,
  parameter int unsigned NUM_EXT         = 2,
  parameter int unsigned CMP_W           = 9,
  parameter int unsigned LINE_W          = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 line_stb,
  input logic [NUM_EXT-1:0]   ext_set,
  input logic                 reg_we,
  input logic [1:0]           reg_addr,
  input logic [7:0]           reg_wdata,
  input logic [7:0]           reg_rdata,
  input logic                 irq_o,
  input logic [LINE_W-1:0]    line_o,
  input logic [NUM_EXT+1:0]   stat_q,
  input logic [NUM_EXT+1:0]   en_q,
  input logic [CMP_W-1:0]     cmp_q
);
  localparam int unsigned NSRC = NUM_EXT + 2;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (line_o == '0 && stat_q == '0 && en_q == '0 && cmp_q == '0)); // R9

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && 32'(line_o) == LINES_PER_FRAME - 1) |=> line_o == '0); // R1

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && 32'(line_o) != LINES_PER_FRAME - 1) |=> line_o == $past(line_o) + 1'b1); // R1

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(line_o)); // R1

  AST_VSYNC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> stat_q[0] == (32'(line_o) >= SYNC_FIRST && 32'(line_o) <= SYNC_LAST)); // R2

  AST_RASTER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> stat_q[1] == (32'(line_o) == 32'($past(cmp_q)))); // R3

  AST_CMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3) |=> cmp_q[8] == $past(reg_wdata[0])); // R4

  AST_EN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=> en_q == $past(reg_wdata[NSRC-1:0])); // R5

  AST_W1C_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1 && reg_wdata[NSRC-1] && !ext_set[NUM_EXT-1]) |=> !stat_q[NSRC-1]); // R6

  AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> ((reg_rdata[NSRC-1:0] & ~en_q) == '0 && reg_rdata[7:NSRC] == '0)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_set[0] |=> stat_q[2]); // R8

endmodule

bind rstr_irq_unit rstr_irq_chk #(
  .LINES_PER_FRAME(LINES_PER_FRAME),
  .SYNC_FIRST     (SYNC_FIRST),
  .SYNC_LAST      (SYNC_LAST),
  .NUM_EXT        (NUM_EXT),
  .CMP_W          (CMP_W),
  .LINE_W         (LINE_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_stb (line_stb),
  .ext_set  (ext_set),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .irq_o    (irq_o),
  .line_o   (line_o),
  .stat_q   (stat_q),
  .en_q     (en_q),
  .cmp_q    (cmp_q)
);

// File: tb/test_rstr_irq_unit.sv
`timescale 1ns/1ps
module test_rstr_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0;
  logic [1:0] ext_set = 2'b00;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_o;
  logic [9:0] line_o;

  always #2 clk = ~clk;

  rstr_irq_unit i_rstr_irq_unit (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .ext_set(ext_set),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .line_o(line_o)
  );

  // bench model of the requirements
  int       m_line;
  bit [3:0] m_en;
  bit [3:0] m_stat;
  int       m_cmp;
  int       n_cmp = 0;
  int       n_bad = 0;
  bit       done = 1'b0;

  typedef struct {
    int    kind;  // 0 read data, 1 irq, 2 line
    int    exp;
    string tag;
    string what;
  } item_t;
  item_t sb_q[$];

  function automatic bit m_sync(int l);
    return l >= 492 && l <= 495;
  endfunction

  function automatic int m_next(int l);
    return (l == 524) ? 0 : l + 1;
  endfunction

  // monitor: one expected item per cycle, compared away from the edge
  always @(negedge clk) begin
    item_t it;
    int act;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        0: act = int'(reg_rdata);
        1: act = int'(irq_o);
        default: act = int'(line_o);
      endcase
      n_cmp++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s %s: actual=%0h expected=%0h", it.tag, it.what, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [1:0] a, int exp, string tag, string what);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.kind = kind; it.exp = exp; it.tag = tag; it.what = what;
    sb_q.push_back(it);
  endtask

  task automatic check_all(string tag);
    push(0, 2'd0, int'(m_en), tag, "enable read");
    push(0, 2'd1, int'(m_stat & m_en), tag, "status read");
    push(0, 2'd2, m_cmp & 8'hFF, tag, "compare low read");
    push(0, 2'd3, (m_cmp >> 8) & 1, tag, "compare high read");
    push(1, 2'd1, int'(|(m_stat & m_en)), tag, "irq");
    push(2, 2'd1, m_line, tag, "line");
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    case (a)
      2'd0: m_en = d[3:0];
      2'd1: m_stat = m_stat & ~d[3:0];
      2'd2: m_cmp = (m_cmp & 32'h100) | int'(d);
      default: m_cmp = (m_cmp & 32'hFF) | (int'(d[0]) << 8);
    endcase
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      line_stb = 1'b1;
      @(posedge clk); #1;
      line_stb = 1'b0;
      m_line = m_next(m_line);
      m_stat[0] = m_sync(m_line);
      m_stat[1] = (m_line == m_cmp);
    end
  endtask

  task automatic pulse(logic [1:0] m);
    @(posedge clk); #1;
    ext_set = m;
    @(posedge clk); #1;
    ext_set = 2'b00;
    m_stat = m_stat | {m, 2'b00};
  endtask

  // strobe, both external pulses and an all-ones clear in one cycle
  task automatic collide();
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h0F;
    ext_set = 2'b11; line_stb = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; ext_set = 2'b00; line_stb = 1'b0;
    m_line = m_next(m_line);
    m_stat[0] = m_sync(m_line);
    m_stat[1] = (m_line == m_cmp);
    m_stat[3:2] = 2'b11;
  endtask

  initial begin
    m_line = 0; m_en = 0; m_stat = 0; m_cmp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R9");

    wr(2'd0, 8'hFF);                 // R5: upper bits ignored
    check_all("R5");
    wr(2'd2, 8'h05);
    wr(2'd3, 8'hFF);                 // R4: compare becomes 0x105
    check_all("R4");
    wr(2'd3, 8'h00);                 // compare 5
    check_all("R4");

    strobe(5);                       // R3: line 5 matches
    check_all("R3");
    strobe(1);
    check_all("R3");

    strobe(486);                     // R2: line 492 enters sync band
    check_all("R2");
    strobe(3);                       // line 495, still in band
    check_all("R2");
    strobe(1);                       // line 496, out of band
    check_all("R2");

    strobe(28);                      // R1: line 524
    check_all("R1");
    strobe(1);                       // wraps to 0
    check_all("R1");

    pulse(2'b01);                    // R8: sprite bit 2
    wr(2'd0, 8'h0B);                 // R7: bit 2 masked from read and irq
    check_all("R7");
    wr(2'd0, 8'h0F);
    check_all("R7");

    pulse(2'b10);
    wr(2'd1, 8'h04);                 // R6: clears only bit 2
    check_all("R6");
    wr(2'd1, 8'h08);
    check_all("R6");

    wr(2'd2, 8'h01);                 // compare line 1, next strobe matches
    collide();                       // R8: set and strobe update beat the clear
    check_all("R8");

    wr(2'd2, 8'h05);
    wr(2'd3, 8'h01);                 // compare 261
    strobe(260);                     // R3/R4: line 261
    check_all("R4");
    wr(2'd1, 8'h0F);                 // R6: everything cleared
    check_all("R6");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule